// File: doc/BRIEF.md
# Line Interface Serial Register Master

This block reads and writes the registers of a line interface device over a small serial control port. That device has 16 registers, each with a 4-bit address and 5 bits of data. The requester puts a direction, a register address, write data and a slot index on the inputs and pulses `start`. The block then performs the complete transaction on the serial pins and pulses `done` when it finishes. After a read, the block keeps the result on `rdata` until the next read completes.

A transaction always has three steps. First, the block drives the chip-select code of the addressed slot. Second, it clocks out a 16-bit frame. Third, it returns the select lines to zero. Each frame bit uses one low phase and one high phase of `sclk`. `sdo` changes only while `sclk` is low. Input bits are captured at the end of the high phase. A read sends 8 bits and then receives 8 bits. A write sends all 16 bits. All fields go out least significant bit first.

Top module: `lif_serial_master`

## Requirements
- R1: After reset, `busy`, `done`, `sclk`, `sdo`, `sel` and `rdata` are all zero.
- R2: Frame bit 0 is the direction flag: 1 for a read, 0 for a write.
- R3: Frame bits 1 to 4 carry the register address, least significant bit first. Frame bits 5 to 7 are zero.
- R4: On a write, frame bits 8 to 12 carry the 5 data bits, least significant bit first. Frame bits 13 to 15 are zero.
- R5: On a read, `sdo` is 0 for frame bits 8 to 15. `sdi` is captured during each of those bits' high phase, least significant bit first. `rdata` takes only the low 5 of the 8 captured bits.
- R6: From the first busy cycle to the last, `sel` holds the code of the requested slot. The default codes are 2'b01 for slot 0 and 2'b10 for slot 1. At all other times `sel` is 0.
- R7: Each bit has a low phase of `sclk` followed by a high phase, and each phase lasts PHASE_CYC cycles. A transaction keeps `busy` high for exactly 34*PHASE_CYC cycles: one select phase, 32 bit phases and one trailing low phase. `sclk` is low whenever the block is idle.
- R8: `done` is high for exactly one cycle after each transaction. `busy` is already low in that cycle.
- R9: A `start` that arrives while `busy` is high has no effect. The running frame, the number of bits and the number of `done` pulses are unchanged.
- R10: `rdata` holds the last value read. A write does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled only while idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 5 | Write data |
| slot | input | SLOT_W | Target slot index |
| sdi | input | 1 | Serial data from the device |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 5 | Last read result |
| sel | output | SEL_W | Chip-select code of the active slot |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the device |

## Verification
The hardest case to create is a `start` that lands in the middle of a transaction. Requests normally arrive only after `done`, so this case needs deliberate stimulus. The bench raises `start` with the opposite direction ten busy cycles into a write. It then checks four things: the captured frame is still the write frame, exactly 16 clock rises occur, one `done` pulse appears, and no second transaction follows. A second subtle case is a read whose 3 padding bits come back as ones. The bench's device model returns such responses, which shows that only the low 5 bits reach `rdata`.

// File: rtl/lsm_pkg.sv
// Shared constants and state type for the serial register master.
// Assumes a fixed 16-bit frame: 8 bits out, then 8 more bits out or in.
package lsm_pkg;
    localparam int ADDR_BITS  = 4;
    localparam int DATA_BITS  = 5;
    localparam int FIELD_BITS = 8;
    localparam int FRAME_BITS = 2 * FIELD_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int RXI_W      = $clog2(FIELD_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_LO,
        ST_HI,
        ST_TAIL
    } lsm_state_t;
endpackage

// File: rtl/lsm_phase_timer.sv
// Phase timer: produces a tick on the last cycle of every PHASE_CYC-cycle phase.
// Assumes run is held high for the whole transaction; the count restarts at zero when run is low.
module lsm_phase_timer #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(PHASE_CYC) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/lsm_frame_build.sv
// Frame builder: packs direction, address and write data into the 16-bit serial frame.
// Assumes bit 0 leaves first; padding bits are zero; a read carries no data bits.
module lsm_frame_build
    import lsm_pkg::*;
(
    input  logic                  rd,
    input  logic [ADDR_BITS-1:0]  addr,
    input  logic [DATA_BITS-1:0]  wdata,
    output logic [FRAME_BITS-1:0] frame
);
    // Place each field at its bit position in the frame.
    always_comb begin
        frame = '0;
        frame[0] = rd;
        frame[ADDR_BITS:1] = addr;
        if (!rd) begin
            frame[FIELD_BITS +: DATA_BITS] = wdata;
        end
    end
endmodule

// File: rtl/lsm_slot_select.sv
// Slot select decoder: returns the chip-select code that belongs to a slot index.
// Assumes the codes are packed with slot 0 in the low bits; an index beyond the last slot gives zero.
module lsm_slot_select #(
    parameter int NUM_SLOTS = 2,
    parameter int SEL_W     = 2,
    parameter int SLOT_W    = 1,
    parameter logic [NUM_SLOTS*SEL_W-1:0] SEL_CODES = '0
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [SEL_W-1:0]  code
);
    logic [NUM_SLOTS-1:0][SEL_W-1:0] hit;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign hit[s] = (slot == SLOT_W'(s)) ? SEL_CODES[s*SEL_W +: SEL_W] : '0;
    end

    // OR the per-slot matches together; at most one of them is nonzero.
    always_comb begin
        code = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            code = code | hit[s];
        end
    end
endmodule

// File: rtl/lif_serial_master.sv
// Line interface serial register master: runs one select / 16-bit frame / deselect transaction per request.
// Assumes the device latches sdo on the rising edge of sclk and holds sdi stable through each high phase.
module lif_serial_master
    import lsm_pkg::*;
#(
    parameter int PHASE_CYC = 2,
    parameter int NUM_SLOTS = 2,
    parameter int SEL_W     = 2,
    parameter int SLOT_W    = 1,
    parameter logic [NUM_SLOTS*SEL_W-1:0] SEL_CODES = 4'b10_01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  rd_nwr,
    input  logic [ADDR_BITS-1:0]  addr,
    input  logic [DATA_BITS-1:0]  wdata,
    input  logic [SLOT_W-1:0]     slot,
    input  logic                  sdi,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_BITS-1:0]  rdata,
    output logic [SEL_W-1:0]      sel,
    output logic                  sclk,
    output logic                  sdo
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IN_START = IDX_W'(FIELD_BITS);

    lsm_state_t              state_q;
    logic [IDX_W-1:0]        idx_q;
    logic [FRAME_BITS-1:0]   frame_q;
    logic [FRAME_BITS-1:0]   frame_d;
    logic [FIELD_BITS-1:0]   rx_q;
    logic [RXI_W-1:0]        rx_idx;
    logic [SEL_W-1:0]        code_d;
    logic [SEL_W-1:0]        sel_q;
    logic                    rd_q;
    logic                    done_q;
    logic [DATA_BITS-1:0]    rdata_q;
    logic                    tick;
    logic                    run;

    assign run = (state_q != ST_IDLE);

    lsm_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    lsm_frame_build u_frame (
        .rd    (rd_nwr),
        .addr  (addr),
        .wdata (wdata),
        .frame (frame_d)
    );

    lsm_slot_select #(
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (SEL_W),
        .SLOT_W    (SLOT_W),
        .SEL_CODES (SEL_CODES)
    ) u_sel (
        .slot (slot),
        .code (code_d)
    );

    assign rx_idx = RXI_W'(idx_q - IN_START);

    // Sequence the transaction and capture incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            frame_q <= '0;
            rx_q    <= '0;
            sel_q   <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SEL;
                        frame_q <= frame_d;
                        rd_q    <= rd_nwr;
                        sel_q   <= code_d;
                        idx_q   <= '0;
                        rx_q    <= '0;
                    end
                end
                ST_SEL: begin
                    if (tick) state_q <= ST_LO;
                end
                ST_LO: begin
                    if (tick) state_q <= ST_HI;
                end
                ST_HI: begin
                    if (tick) begin
                        if (rd_q && idx_q >= IN_START) begin
                            rx_q[rx_idx] <= sdi;
                        end
                        if (idx_q == LAST_IDX) begin
                            state_q <= ST_TAIL;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_LO;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        sel_q   <= '0;
                        done_q  <= 1'b1;
                        if (rd_q) rdata_q <= rx_q[DATA_BITS-1:0];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy  = run;
    assign done  = done_q;
    assign rdata = rdata_q;
    assign sel   = sel_q;
    assign sclk  = (state_q == ST_HI);
    assign sdo   = (state_q == ST_LO || state_q == ST_HI) && frame_q[idx_q];

    // R6: select is zero whenever no transaction runs.
    assert_sel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sel == '0));

    // R6: select holds one code for the whole transaction.
    assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(sel)));

    // R7: serial clock stays low while idle.
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R8: done lasts one cycle and comes only after the transaction has ended.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9: a start during a transaction leaves the latched frame unchanged.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(frame_q));

    // R10: a write never disturbs the read result.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_q) |=> $stable(rdata));
endmodule

// File: tb/lif_serial_master_tb.sv
module lif_serial_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE_CYC  = 2;
    localparam int XFER_CYC   = 34 * PHASE_CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [3:0] addr = '0;
    logic [4:0] wdata = '0;
    logic       slot = 1'b0;
    logic       sdi = 1'b0;
    logic       busy, done, sclk, sdo;
    logic [4:0] rdata;
    logic [1:0] sel;

    int errors = 0;
    int checks = 0;

    // Device model state
    logic [15:0] cap;
    logic [7:0]  resp;
    logic [1:0]  exp_code;
    int          bit_cnt;
    int          sel_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    lif_serial_master #(.PHASE_CYC(PHASE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .addr(addr), .wdata(wdata), .slot(slot), .sdi(sdi),
        .busy(busy), .done(done), .rdata(rdata), .sel(sel),
        .sclk(sclk), .sdo(sdo)
    );

    // Device model: latch sdo on each rising sclk and present the next response bit.
    always @(posedge sclk) begin
        if (bit_cnt < 16) cap[bit_cnt] = sdo;
        if (sel != exp_code) sel_bad = 1;
        sdi = (bit_cnt >= 8 && bit_cnt < 16) ? resp[bit_cnt-8] : 1'b0;
        bit_cnt = bit_cnt + 1;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input bit rd, input logic [3:0] a,
                                              input logic [4:0] d);
        logic [15:0] f;
        f = '0;
        f[0] = rd;
        f[4:1] = a;
        if (!rd) f[12:8] = d;
        return f;
    endfunction

    // Run one transaction; optionally raise start again in the middle of it.
    task automatic run_xfer(input bit rd, input logic [3:0] a, input logic [4:0] d,
                            input bit s, input logic [7:0] r, input bit poke);
        int cyc;
        int guard;
        int extra_done;
        logic [15:0] ef;
        bit_cnt  = 0;
        sel_bad  = 0;
        cap      = '0;
        resp     = r;
        exp_code = s ? 2'b10 : 2'b01;
        @(negedge clk);
        rd_nwr = rd; addr = a; wdata = d; slot = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        guard = 0;
        while (!done && guard < 1000) begin
            if (busy) cyc++;
            if (poke && cyc == 10) begin
                start = 1'b1; rd_nwr = ~rd; addr = ~a; wdata = ~d;
            end else begin
                start = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        ef = exp_frame(rd, a, d);
        check(done == 1'b1 && busy == 1'b0, "R8", "done with busy low", {busy, done}, 2'b01);
        check(cyc == XFER_CYC, "R7", "busy cycle count", cyc, XFER_CYC);
        check(bit_cnt == 16, "R7", "sclk rises", bit_cnt, 16);
        check(cap[0] == rd, "R2", "direction bit", cap[0], rd);
        check(cap[7:0] == ef[7:0], "R3", "address field", cap[7:0], ef[7:0]);
        if (rd) check(cap[15:8] == 8'h00, "R5", "sdo low while receiving", cap[15:8], 0);
        else    check(cap[15:8] == ef[15:8], "R4", "data field", cap[15:8], ef[15:8]);
        check(sel_bad == 0, "R6", "select code during bits", sel_bad, 0);
        check(sel == 2'b00 && sclk == 1'b0, "R6", "select cleared after", {sel, sclk}, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width one cycle", done, 0);
        extra_done = 0;
        for (int i = 0; i < 6; i++) begin
            if (done || busy) extra_done++;
            @(negedge clk);
        end
        if (poke) check(extra_done == 0, "R9", "no second transaction", extra_done, 0);
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0 && sclk == 0 && sdo == 0, "R1", "control outputs",
              {busy, done, sclk, sdo}, 0);
        check(sel == 0 && rdata == 0, "R1", "sel and rdata", {sel, rdata}, 0);
    endtask

    task automatic t_write_slot0();
        run_xfer(1'b0, 4'hA, 5'h15, 1'b0, 8'h00, 1'b0);
        check(rdata == 5'h00, "R10", "rdata after first write", rdata, 0);
    endtask

    task automatic t_read_slot1();
        // Upper three response bits are ones and must be dropped.
        run_xfer(1'b1, 4'h3, 5'h00, 1'b1, 8'hF6, 1'b0);
        check(rdata == 5'h16, "R5", "read low five bits", rdata, 5'h16);
    endtask

    task automatic t_write_keeps_rdata();
        run_xfer(1'b0, 4'h5, 5'h0A, 1'b1, 8'hFF, 1'b0);
        check(rdata == 5'h16, "R10", "rdata held over write", rdata, 5'h16);
    endtask

    task automatic t_start_while_busy();
        run_xfer(1'b0, 4'hF, 5'h1F, 1'b0, 8'h00, 1'b1);
        check(rdata == 5'h16, "R9", "ignored start left rdata", rdata, 5'h16);
    endtask

    task automatic t_read_patterns();
        run_xfer(1'b1, 4'h0, 5'h00, 1'b0, 8'hE0, 1'b0);
        check(rdata == 5'h00, "R5", "read with only pad bits set", rdata, 0);
        run_xfer(1'b1, 4'h8, 5'h00, 1'b1, 8'h0B, 1'b0);
        check(rdata == 5'h0B, "R5", "read pattern 0B", rdata, 5'h0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_slot0();
        t_read_slot1();
        t_write_keeps_rdata();
        t_start_while_busy();
        t_read_patterns();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule